// File: doc/BRIEF.md
# LCD Common Waveform Generator

This block produces the common-electrode timing for a segment LCD driver. It runs on a fast system clock and is advanced by one of two oscillator tick enables. As master it divides the selected ticks down to a square-wave common phase. In the two-phase (1/2-duty) mode it also alternates which of two common electrodes is selected, and it broadcasts that choice on a sync line. As slave it takes the phase and the sync from a master device, so that several cascaded drivers stay in step.

Each of the two commons gets a two-bit drive code that the analog output stage turns into a voltage. A bank-select flag tells the segment logic which data latch to show while the current common is selected. The oscillator itself and the analog mid-level generation sit outside this block.

Top module: `lcd_com_gen`

## Requirements
- R1: In master static mode (`is_master`=1, `dyn_mode`=0), `com_out` is a square wave with a period of 2^STATIC_LOG2 counted ticks (default 128).
- R2: In master two-phase mode (`is_master`=1, `dyn_mode`=1), `com_out` has a period of 2^DUTY_LOG2 counted ticks (default 64).
- R3: In master mode, `osc_sel`=1 counts `tick_int` and `osc_sel`=0 counts `tick_ext`. In slave mode `osc_sel` has no effect on any output.
- R4: In slave mode, `com_out` equals `slave_phase_in` delayed by one clock.
- R5: In static mode, both drive codes are 2'b10 while `com_out` is 1 and 2'b00 while it is 0. `sync_out`, `sync_oe` and `bank_sel` stay 0.
- R6: In two-phase mode, exactly one common carries the mid code 2'b01 at any time. In master mode `bank_sel` toggles exactly when `com_out` falls, so it toggles once per `com_out` period.
- R7: The selected common (COM A when `bank_sel`=0, COM B when `bank_sel`=1) carries 2'b10 while `com_out` is 1 and 2'b00 while it is 0. The code 2'b11 never appears.
- R8: In master two-phase mode, `sync_oe` is 1 and `sync_out` is 1 while COM A is selected and 0 while COM B is selected.
- R9: In slave two-phase mode, `bank_sel` equals the inverse of `sync_in` delayed by one clock, and `sync_oe` is 0.
- R10: While `rst` is high, every output is 0 (both codes 2'b00). After `rst` falls, the divider restarts from zero with COM A selected. With a tick on every clock, `com_out` first rises on the clock edge after the 2^(N-1)-th tick, where N is the log2 ratio of the active mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| is_master | input | 1 | 1 = master (own divider), 0 = slave |
| dyn_mode | input | 1 | 1 = two-phase (1/2-duty), 0 = static |
| osc_sel | input | 1 | Tick source: 1 = internal, 0 = external (master only) |
| tick_int | input | 1 | Internal oscillator tick enable |
| tick_ext | input | 1 | External clock tick enable |
| slave_phase_in | input | 1 | Common phase from the master (slave only) |
| sync_in | input | 1 | Sync from the master (slave, two-phase) |
| sync_out | output | 1 | Sync driven by the master |
| sync_oe | output | 1 | Output enable for the sync pad |
| com_out | output | 1 | Common phase for cascading |
| com_a_code | output | 2 | COM A drive: 00 GND, 01 mid, 10 VLCD |
| com_b_code | output | 2 | COM B drive: 00 GND, 01 mid, 10 VLCD |
| bank_sel | output | 1 | Latch bank in use: 0 = A, 1 = B |

## Verification
The bench builds the block with STATIC_LOG2=4 and DUTY_LOG2=3, so a period is 16 or 8 ticks instead of 128 or 64. At these sizes one short run covers several complete phase periods and several bank swaps in every mode and with both tick sources. Because the ratios are small, the first rise after reset and the alignment of each bank toggle with a falling phase can be checked cycle by cycle against counts worked out by hand.

// File: rtl/lcd_com_pkg.sv
package lcd_com_pkg;
  typedef enum logic [1:0] {
    DRV_GND  = 2'b00,
    DRV_MID  = 2'b01,
    DRV_HIGH = 2'b10
  } drv_e;

  function automatic drv_e phase_drive(input logic ph);
    return ph ? DRV_HIGH : DRV_GND;
  endfunction
endpackage

// File: rtl/lcd_com_divider.sv
module lcd_com_divider #(
  parameter int STATIC_LOG2 = 7,
  parameter int DUTY_LOG2   = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic dyn_mode,
  output logic phase,
  output logic bank
);
  localparam int CW = STATIC_LOG2;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= cnt + ONE;
  end

  always_comb begin
    phase = dyn_mode ? cnt[DUTY_LOG2-1] : cnt[CW-1];
    bank  = dyn_mode & cnt[DUTY_LOG2];
  end

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cnt)); // R3
endmodule

// File: rtl/lcd_com_source.sv
module lcd_com_source (
  input  logic is_master,
  input  logic dyn_mode,
  input  logic osc_sel,
  input  logic tick_int,
  input  logic tick_ext,
  input  logic slave_phase_in,
  input  logic sync_in,
  input  logic div_phase,
  input  logic div_bank,
  output logic tick,
  output logic phase,
  output logic bank
);
  always_comb begin
    tick = is_master & (osc_sel ? tick_int : tick_ext);
    if (is_master) begin
      phase = div_phase;
      bank  = div_bank;
    end else begin
      phase = slave_phase_in;
      bank  = dyn_mode & ~sync_in;
    end
  end
endmodule

// File: rtl/lcd_com_drive.sv
module lcd_com_drive
  import lcd_com_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       is_master,
  input  logic       dyn_mode,
  input  logic       phase,
  input  logic       bank,
  output logic       com_out,
  output logic       bank_sel,
  output logic       sync_out,
  output logic       sync_oe,
  output logic [1:0] com_a_code,
  output logic [1:0] com_b_code
);
  localparam int NCOM = 2;

  logic [1:0] code_q [NCOM];

  always_ff @(posedge clk) begin
    if (rst) begin
      com_out  <= 1'b0;
      bank_sel <= 1'b0;
      sync_out <= 1'b0;
      sync_oe  <= 1'b0;
    end else begin
      com_out  <= phase;
      bank_sel <= bank;
      sync_oe  <= is_master & dyn_mode;
      sync_out <= is_master & dyn_mode & ~bank;
    end
  end

  for (genvar i = 0; i < NCOM; i++) begin : g_com
    logic selected;
    assign selected = (i == 0) ? ~bank : bank;
    always_ff @(posedge clk) begin
      if (rst)                       code_q[i] <= DRV_GND;
      else if (!dyn_mode || selected) code_q[i] <= phase_drive(phase);
      else                           code_q[i] <= DRV_MID;
    end
  end

  assign com_a_code = code_q[0];
  assign com_b_code = code_q[1];

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (com_a_code != 2'b11) && (com_b_code != 2'b11)); // R7
  AST_ONE_MID: assert property (@(posedge clk) disable iff (rst)
    dyn_mode |=> ((com_a_code == DRV_MID) != (com_b_code == DRV_MID))); // R6
  AST_STATIC_SAME: assert property (@(posedge clk) disable iff (rst)
    !dyn_mode |=> (com_a_code == com_b_code) && !sync_out && !sync_oe && !bank_sel); // R5
  AST_SEL_PHASE: assert property (@(posedge clk) disable iff (rst)
    dyn_mode |=> ((bank_sel ? com_b_code : com_a_code) == (com_out ? 2'b10 : 2'b00))); // R7
endmodule

// File: rtl/lcd_com_gen.sv
module lcd_com_gen #(
  parameter int STATIC_LOG2 = 7,
  parameter int DUTY_LOG2   = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       is_master,
  input  logic       dyn_mode,
  input  logic       osc_sel,
  input  logic       tick_int,
  input  logic       tick_ext,
  input  logic       slave_phase_in,
  input  logic       sync_in,
  output logic       sync_out,
  output logic       sync_oe,
  output logic       com_out,
  output logic [1:0] com_a_code,
  output logic [1:0] com_b_code,
  output logic       bank_sel
);
  logic tick, div_phase, div_bank, phase, bank;

  lcd_com_divider #(.STATIC_LOG2(STATIC_LOG2), .DUTY_LOG2(DUTY_LOG2)) u_div (
    .clk(clk), .rst(rst), .tick(tick), .dyn_mode(dyn_mode),
    .phase(div_phase), .bank(div_bank));

  lcd_com_source u_src (
    .is_master(is_master), .dyn_mode(dyn_mode), .osc_sel(osc_sel),
    .tick_int(tick_int), .tick_ext(tick_ext), .slave_phase_in(slave_phase_in),
    .sync_in(sync_in), .div_phase(div_phase), .div_bank(div_bank),
    .tick(tick), .phase(phase), .bank(bank));

  lcd_com_drive u_drv (
    .clk(clk), .rst(rst), .is_master(is_master), .dyn_mode(dyn_mode),
    .phase(phase), .bank(bank), .com_out(com_out), .bank_sel(bank_sel),
    .sync_out(sync_out), .sync_oe(sync_oe),
    .com_a_code(com_a_code), .com_b_code(com_b_code));

  AST_SLAVE_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !is_master |=> (com_out == $past(slave_phase_in))); // R4
  AST_SLAVE_SYNC: assert property (@(posedge clk) disable iff (rst)
    (!is_master && dyn_mode) |=> (bank_sel == !$past(sync_in)) && !sync_oe); // R9
  AST_MASTER_SYNC: assert property (@(posedge clk) disable iff (rst)
    (is_master && dyn_mode) |=> sync_oe && (sync_out == !bank_sel)); // R8
endmodule

// File: tb/lcd_com_gen_test.sv
module lcd_com_gen_test;
  localparam int SL = 4;
  localparam int DL = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic is_master = 1'b1, dyn_mode = 1'b0, osc_sel = 1'b1;
  logic tick_int = 1'b1, tick_ext = 1'b0;
  logic slave_phase_in = 1'b0, sync_in = 1'b0;
  logic sync_out, sync_oe, com_out, bank_sel;
  logic [1:0] com_a_code, com_b_code;

  int checks = 0, errors = 0, cyc = 0;

  lcd_com_gen #(.STATIC_LOG2(SL), .DUTY_LOG2(DL)) uut (
    .clk(clk), .rst(rst), .is_master(is_master), .dyn_mode(dyn_mode),
    .osc_sel(osc_sel), .tick_int(tick_int), .tick_ext(tick_ext),
    .slave_phase_in(slave_phase_in), .sync_in(sync_in),
    .sync_out(sync_out), .sync_oe(sync_oe), .com_out(com_out),
    .com_a_code(com_a_code), .com_b_code(com_b_code), .bank_sel(bank_sel));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    tick_ext <= ~tick_ext;
    if (cyc > 20000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 20000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // fields: dyn_mode, osc_sel, expected period in clocks (ext ticks every 2nd clock)
  localparam int VEC [4][3] = '{
    '{0, 1, 1 << SL},
    '{0, 0, 2 << SL},
    '{1, 1, 1 << DL},
    '{1, 0, 2 << DL}
  };

  initial begin
    for (int v = 0; v < 4; v++) begin
      int rise_n, first_rise, last_rise, period, flip_n;
      logic pc, pb;
      is_master = 1'b1; dyn_mode = VEC[v][0][0]; osc_sel = VEC[v][1][0];
      rst = 1'b1;
      step(); step();
      // R10: outputs cleared during reset
      chk({com_out, bank_sel, sync_out, sync_oe, com_a_code, com_b_code} == 0,
          "R10 reset outputs", {com_out, bank_sel, sync_out, sync_oe, com_a_code, com_b_code}, 0);
      rst = 1'b0;
      pc = 1'b0; pb = 1'b0; rise_n = 0; first_rise = 0; last_rise = 0; period = 0; flip_n = 0;
      for (int n = 1; n <= 4 * VEC[v][2] + 4; n++) begin
        logic [1:0] pcode;
        step();
        pcode = com_out ? 2'b10 : 2'b00;
        if (!dyn_mode) begin
          // R5: static commons follow phase, no sync, bank A
          chk(com_a_code == pcode && com_b_code == pcode, "R5 static codes",
              {com_a_code, com_b_code}, {pcode, pcode});
          chk(!sync_out && !sync_oe && !bank_sel, "R5 static sync/bank",
              {sync_out, sync_oe, bank_sel}, 0);
        end else begin
          // R7: selected common follows phase; R6: other is mid
          chk((bank_sel ? com_b_code : com_a_code) == pcode, "R7 selected code",
              bank_sel ? com_b_code : com_a_code, pcode);
          chk((bank_sel ? com_a_code : com_b_code) == 2'b01, "R6 unselected mid",
              bank_sel ? com_a_code : com_b_code, 1);
          chk((bank_sel != pb) == (pc && !com_out), "R6 bank toggles on fall",
              bank_sel, pb);
          chk(sync_oe && sync_out == !bank_sel, "R8 master sync",
              {sync_oe, sync_out}, {1'b1, !bank_sel});
          if (bank_sel != pb && flip_n == 0) flip_n = n;
        end
        if (com_out && !pc) begin
          rise_n++;
          if (rise_n == 1) first_rise = n;
          if (rise_n == 3) period = n - last_rise;
          last_rise = n;
        end
        pc = com_out; pb = bank_sel;
      end
      // R1 static, R2 two-phase, R3 tick source
      chk(period == VEC[v][2], dyn_mode ? "R2 period (R3 source)" : "R1 period (R3 source)",
          period, VEC[v][2]);
      if (osc_sel) begin
        chk(first_rise == (1 << ((dyn_mode ? DL : SL) - 1)) + 1, "R10 first rise",
            first_rise, (1 << ((dyn_mode ? DL : SL) - 1)) + 1);
        if (dyn_mode)
          chk(flip_n == (1 << DL) + 1, "R10 COM A selected first", flip_n, (1 << DL) + 1);
      end
    end

    // Slave two-phase: R4, R9, osc_sel ignored (R3)
    is_master = 1'b0; dyn_mode = 1'b1;
    rst = 1'b1; step(); rst = 1'b0;
    for (int i = 0; i < 24; i++) begin
      logic pp, ps;
      pp = (i / 3) % 2; ps = (i / 5) % 2;
      slave_phase_in = pp; sync_in = ps; osc_sel = i % 2;
      step();
      chk(com_out == pp, "R4 slave phase follow (R3 osc_sel ignored)", com_out, pp);
      chk(bank_sel == !ps && !sync_oe && !sync_out, "R9 slave bank from sync",
          {bank_sel, sync_oe, sync_out}, {!ps, 2'b00});
    end

    // Slave static: R5
    dyn_mode = 1'b0;
    for (int i = 0; i < 6; i++) begin
      slave_phase_in = i % 2; sync_in = 1'b1;
      step();
      chk(!bank_sel && !sync_out && !sync_oe, "R5 slave static", {bank_sel, sync_out, sync_oe}, 0);
      chk(com_a_code == ((i % 2) ? 2'b10 : 2'b00) && com_b_code == com_a_code,
          "R5 slave static codes", com_a_code, (i % 2) ? 2 : 0);
    end

    // Mid-run reset: R10
    is_master = 1'b1; dyn_mode = 1'b1; osc_sel = 1'b1;
    for (int i = 0; i < 13; i++) step();
    rst = 1'b1; step();
    chk({com_out, bank_sel, com_a_code, com_b_code} == 0, "R10 mid-run reset",
        {com_out, bank_sel, com_a_code, com_b_code}, 0);
    rst = 1'b0; step();
    chk(!bank_sel && com_b_code == 2'b01 && com_a_code == 2'b00, "R10 restart A selected",
        {bank_sel, com_a_code, com_b_code}, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule